// File: doc/BRIEF.md
# SPI Serial Nonvolatile Memory Command Engine

This block is the slave side of a byte-wide serial memory that is reached over a four-wire SPI link in mode 0. The serial pins are brought into a faster system clock through synchronisers. Clock and select edges are detected in that domain. A transaction opens on a falling chip select and closes on the next rising one. The first byte is an instruction. An array read or array write instruction is followed by a 24-bit address, sent most significant bit first. Read data leaves on a serial output pin that has a separate drive enable, so the output can be tristated outside the chip.

Write data is first staged in a 256-byte page buffer, and a valid mask records which bytes arrived. When the transaction closes on a byte boundary, a commit sequencer copies only the received bytes into the synchronous storage array. It then stays busy for a settling period that stands in for the programming time. A write-enable latch gates every write. A small status byte reports busy, the latch, and three user bits that software can write. A hold input pauses a transfer at any bit without losing its place.

Top module: `spi_nvm_engine`

## Requirements
- R1: The instruction byte is decoded only when its upper nibble is zero, and bit 3 is ignored. Low three bits 110 set the write-enable latch. 100 clears it. 101 reads status. 001 writes status. 011 reads the array. 010 writes the array.
- R2: Instruction, address and data move most significant bit first. An array instruction takes three address bytes. Address bits at and above ADDR_W (default 11) are ignored.
- R3: While chip select is high, the output enable stays low and activity on SCK and SI changes nothing.
- R4: An instruction with a nonzero upper nibble, or with low bits 000 or 111, keeps the output enable low and ignores all input until the next falling chip select.
- R5: An array read returns the byte at the address, then the following bytes in order, for as long as the clock runs. The address wraps from the top of the array to 0. SI is ignored during the data phase.
- R6: An array write places successive bytes at successive columns of the page (address bits 7:0). The column wraps from 255 to 0, and the page bits stay fixed, so a later byte overwrites an earlier one.
- R7: Staged bytes are programmed only when chip select rises while SCK is low, directly after the last bit of a complete data byte. If chip select rises in the middle of a byte, the array and the latch are left unchanged.
- R8: Only the columns received in the transaction are programmed. Every other byte of the page keeps its value.
- R9: HOLD low, taken while SCK is low, floats the output and freezes the bit position. SCK edges and SI are ignored until HOLD returns high while SCK is low. The transfer then resumes at the bit where it stopped.
- R10: The latch changes on the eighth bit of the set or clear instruction. An array write or status write received with the latch clear is ignored. The latch clears when a programming cycle ends and when a status write completes.
- R11: Status read gives bit0 = busy, bit1 = latch, bits 3:2 and bit7 = user bits set by a status write, and bits 6:4 = 0. While busy it reads 0xFF, and every instruction except status read is ignored.
- R12: After reset the output enable is low, the latch is clear and the status reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| csn_i | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| holdn_i | input | 1 | Active-low pause request |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Drive enable for so_o |

## Verification
A pin change reaches the engine two clocks later through the synchronisers, and the edge is acted on in that cycle. A new output bit therefore appears three clocks after SCK falls, and the hold state follows HOLD with the same delay. The bench holds each SCK phase for five clocks and samples the output just before it raises SCK, so the timing has margin. Busy rises three clocks after chip select rises and lasts 256 + SETTLE_CYC clocks. The bench reads status at once to see 0xFF, then polls until busy clears before it compares array contents with its model. The output enable is compared on every clock once chip select has been high for more than four clocks.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;
  localparam int BYTE_W = 8;
  localparam int PAGE_COLS = 256;

  localparam logic [2:0] OP_WEL_SET = 3'b110;
  localparam logic [2:0] OP_WEL_CLR = 3'b100;
  localparam logic [2:0] OP_SR_RD   = 3'b101;
  localparam logic [2:0] OP_SR_WR   = 3'b001;
  localparam logic [2:0] OP_ARR_RD  = 3'b011;
  localparam logic [2:0] OP_ARR_WR  = 3'b010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RD, ST_WR, ST_SRR, ST_SRW, ST_SKIP
  } seq_st_t;

  typedef enum logic [1:0] {CM_IDLE, CM_WALK, CM_SETTLE} cm_st_t;
endpackage

// File: rtl/spi_nvm_front.sv
module spi_nvm_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic csn_i,
  input  logic si_i,
  input  logic holdn_i,
  output logic rst_q_n,
  output logic cs_act,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_bit,
  output logic hold_act
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [1:0]   rst_pipe;
  logic [MSB:0] sck_p, csn_p, si_p, hold_p;
  logic         sck_d, csn_d, hold_q, hold_n;
  logic         sck_s, csn_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sck_p  <= '0;
      csn_p  <= '1;
      si_p   <= '0;
      hold_p <= '1;
      sck_d  <= 1'b0;
      csn_d  <= 1'b1;
      hold_q <= 1'b0;
    end else begin
      sck_p  <= {sck_p[MSB-1:0], sck_i};
      csn_p  <= {csn_p[MSB-1:0], csn_i};
      si_p   <= {si_p[MSB-1:0], si_i};
      hold_p <= {hold_p[MSB-1:0], holdn_i};
      sck_d  <= sck_s;
      csn_d  <= csn_s;
      hold_q <= hold_n;
    end
  end

  assign sck_s  = sck_p[MSB];
  assign csn_s  = csn_p[MSB];
  assign si_bit = si_p[MSB];

  // pause state only changes while the serial clock is low
  always_comb begin
    hold_n = hold_q;
    if (csn_s)       hold_n = 1'b0;
    else if (!sck_s) hold_n = ~hold_p[MSB];
  end

  assign cs_act   = ~csn_s;
  assign cs_fall  = csn_d & ~csn_s;
  assign cs_rise  = ~csn_d & csn_s;
  assign hold_act = hold_q;
  assign sck_rise = sck_s & ~sck_d & ~csn_s & ~hold_q;
  assign sck_fall = ~sck_s & sck_d & ~csn_s & ~hold_q;
endmodule

// File: rtl/spi_nvm_mem.sv
module spi_nvm_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/spi_nvm_commit.sv
module spi_nvm_commit
  import spi_nvm_pkg::*;
#(
  parameter int AW         = 11,
  parameter int SETTLE_CYC = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stage_clr,
  input  logic          stage_we,
  input  logic [7:0]    stage_col,
  input  logic [7:0]    stage_data,
  input  logic          start,
  input  logic [AW-9:0] page_i,
  output logic          busy,
  output logic          done,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  cm_st_t               ph_q, ph_n;
  logic [7:0]           idx_q, idx_n;
  logic [CW-1:0]        cnt_q, cnt_n;
  logic [AW-9:0]        page_q, page_n;
  logic [PAGE_COLS-1:0] valid_q, valid_n;
  logic [7:0]           stage_buf [PAGE_COLS];

  always_ff @(posedge clk) begin
    if (stage_we) stage_buf[stage_col] <= stage_data;
  end

  always_comb begin
    valid_n = valid_q;
    if (stage_clr)     valid_n = '0;
    else if (stage_we) valid_n[stage_col] = 1'b1;
  end

  always_comb begin
    ph_n   = ph_q;
    idx_n  = idx_q;
    cnt_n  = cnt_q;
    page_n = page_q;
    done   = 1'b0;
    case (ph_q)
      CM_IDLE: if (start) begin
        ph_n   = CM_WALK;
        idx_n  = '0;
        page_n = page_i;
      end
      CM_WALK: begin
        idx_n = idx_q + 8'd1;
        if (idx_q == 8'hFF) begin
          ph_n  = CM_SETTLE;
          cnt_n = CW'(SETTLE_CYC - 1);
        end
      end
      CM_SETTLE: begin
        if (cnt_q == '0) begin
          ph_n = CM_IDLE;
          done = 1'b1;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      default: ph_n = CM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= CM_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      page_q  <= '0;
      valid_q <= '0;
    end else begin
      ph_q    <= ph_n;
      idx_q   <= idx_n;
      cnt_q   <= cnt_n;
      page_q  <= page_n;
      valid_q <= valid_n;
    end
  end

  assign busy      = (ph_q != CM_IDLE);
  assign mem_we    = (ph_q == CM_WALK) && valid_q[idx_q];
  assign mem_waddr = {page_q, idx_q};
  assign mem_wdata = stage_buf[idx_q];
endmodule

// File: rtl/spi_nvm_seq.sv
module spi_nvm_seq
  import spi_nvm_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          si_bit,
  input  logic          hold_act,
  input  logic          busy,
  input  logic          wr_done,
  input  logic [7:0]    mem_rdata,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic          stage_clr,
  output logic          stage_we,
  output logic [7:0]    stage_col,
  output logic [7:0]    stage_data,
  output logic          commit_go,
  output logic [AW-9:0] commit_page,
  output logic          so_o,
  output logic          so_oe_o,
  output logic          wel_o,
  output logic          out_phase
);
  seq_st_t       st_q, st_n;
  logic [2:0]    bit_q, bit_n;
  logic [1:0]    ab_q, ab_n;
  logic [7:0]    sh_q, sh_n, out_q, out_n, src;
  logic [AW-1:0] addr_q, addr_n;
  logic          wel_q, wel_n, pen_q, pen_n, got_q, got_n;
  logic          wr_q, wr_n, oe_q, oe_n, so_q, so_n;
  logic [1:0]    bp_q, bp_n;
  logic [7:0]    byte_in, status_val;
  logic [AW+7:0] addr_shift;
  logic          byte_done;

  assign byte_in    = {sh_q[6:0], si_bit};
  assign addr_shift = {addr_q, byte_in};
  assign byte_done  = sck_rise && (bit_q == 3'd7);
  assign status_val = busy ? 8'hFF : {pen_q, 3'b000, bp_q, wel_q, 1'b0};

  always_comb begin
    st_n = st_q;   bit_n = bit_q;   ab_n = ab_q;   sh_n = sh_q;
    addr_n = addr_q; wel_n = wel_q; bp_n = bp_q;   pen_n = pen_q;
    got_n = got_q; wr_n = wr_q;     oe_n = oe_q;   so_n = so_q;
    out_n = out_q; src = 8'h00;
    mem_re = 1'b0; stage_clr = 1'b0; stage_we = 1'b0; commit_go = 1'b0;
    if (wr_done) wel_n = 1'b0;
    if (cs_fall) begin
      st_n = ST_OPC; bit_n = '0; ab_n = '0; got_n = 1'b0; oe_n = 1'b0;
    end else if (cs_rise) begin
      if (st_q == ST_WR && bit_q == 3'd0 && got_q) commit_go = 1'b1;
      if (st_q == ST_SRW && bit_q == 3'd0 && got_q) begin
        pen_n = sh_q[7];
        bp_n  = sh_q[3:2];
        wel_n = 1'b0;
      end
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else begin
      if (sck_rise) begin
        bit_n = bit_q + 3'd1;
        sh_n  = byte_in;
      end
      case (st_q)
        ST_OPC: if (byte_done) begin
          st_n = ST_SKIP;
          if (byte_in[7:4] == 4'h0 && (!busy || byte_in[2:0] == OP_SR_RD)) begin
            case (byte_in[2:0])
              OP_WEL_SET: wel_n = 1'b1;
              OP_WEL_CLR: wel_n = 1'b0;
              OP_SR_RD:   st_n = ST_SRR;
              OP_SR_WR:   if (wel_q) st_n = ST_SRW;
              OP_ARR_RD:  begin st_n = ST_ADDR; wr_n = 1'b0; end
              OP_ARR_WR:  if (wel_q) begin
                st_n = ST_ADDR; wr_n = 1'b1; stage_clr = 1'b1;
              end
              default: ;
            endcase
          end
        end
        ST_ADDR: if (byte_done) begin
          addr_n = addr_shift[AW-1:0];
          ab_n   = ab_q + 2'd1;
          if (ab_q == 2'd2) begin
            if (wr_q) st_n = ST_WR;
            else begin
              st_n   = ST_RD;
              mem_re = 1'b1;
            end
          end
        end
        ST_RD, ST_SRR: begin
          if (byte_done && st_q == ST_RD) begin
            addr_n = addr_q + 1'b1;
            mem_re = 1'b1;
          end
          if (sck_fall) begin
            oe_n = 1'b1;
            if (bit_q == 3'd0) begin
              src   = (st_q == ST_RD) ? mem_rdata : status_val;
              so_n  = src[7];
              out_n = {src[6:0], 1'b0};
            end else begin
              so_n  = out_q[7];
              out_n = {out_q[6:0], 1'b0};
            end
          end
        end
        ST_WR: if (byte_done) begin
          stage_we     = 1'b1;
          addr_n[7:0]  = addr_q[7:0] + 8'd1;
          got_n        = 1'b1;
        end
        ST_SRW: if (byte_done) got_n = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; bit_q <= '0; ab_q <= '0; sh_q <= '0; out_q <= '0;
      addr_q <= '0; wel_q <= 1'b0; bp_q <= '0; pen_q <= 1'b0;
      got_q <= 1'b0; wr_q <= 1'b0; oe_q <= 1'b0; so_q <= 1'b0;
    end else begin
      st_q <= st_n; bit_q <= bit_n; ab_q <= ab_n; sh_q <= sh_n; out_q <= out_n;
      addr_q <= addr_n; wel_q <= wel_n; bp_q <= bp_n; pen_q <= pen_n;
      got_q <= got_n; wr_q <= wr_n; oe_q <= oe_n; so_q <= so_n;
    end
  end

  assign mem_raddr   = addr_n;
  assign stage_col   = addr_q[7:0];
  assign stage_data  = byte_in;
  assign commit_page = addr_q[AW-1:8];
  assign so_o        = so_q;
  assign so_oe_o     = oe_q & cs_act & ~hold_act;
  assign wel_o       = wel_q;
  assign out_phase   = (st_q == ST_RD) || (st_q == ST_SRR);
endmodule

// File: rtl/spi_nvm_engine.sv
module spi_nvm_engine #(
  parameter int ADDR_W      = 11,
  parameter int SETTLE_CYC  = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic csn_i,
  input  logic si_i,
  input  logic holdn_i,
  output logic so_o,
  output logic so_oe_o
);
  localparam int PAGE_W = ADDR_W - 8;

  logic              rst_q_n, cs_act, cs_fall, cs_rise, sck_rise, sck_fall;
  logic              si_bit, hold_act, busy, wr_done, wel, out_phase;
  logic              mem_re, mem_we, stage_clr, stage_we, commit_go;
  logic [ADDR_W-1:0] mem_raddr, mem_waddr;
  logic [7:0]        mem_rdata, mem_wdata, stage_col, stage_data;
  logic [PAGE_W-1:0] commit_page;

  spi_nvm_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .csn_i(csn_i), .si_i(si_i),
    .holdn_i(holdn_i), .rst_q_n(rst_q_n), .cs_act(cs_act), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .si_bit(si_bit), .hold_act(hold_act)
  );

  spi_nvm_seq #(.AW(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_q_n), .cs_act(cs_act), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .si_bit(si_bit), .hold_act(hold_act), .busy(busy), .wr_done(wr_done),
    .mem_rdata(mem_rdata), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .stage_clr(stage_clr), .stage_we(stage_we), .stage_col(stage_col),
    .stage_data(stage_data), .commit_go(commit_go), .commit_page(commit_page),
    .so_o(so_o), .so_oe_o(so_oe_o), .wel_o(wel), .out_phase(out_phase)
  );

  spi_nvm_commit #(.AW(ADDR_W), .SETTLE_CYC(SETTLE_CYC)) u_commit (
    .clk(clk), .rst_n(rst_q_n), .stage_clr(stage_clr), .stage_we(stage_we),
    .stage_col(stage_col), .stage_data(stage_data), .start(commit_go),
    .page_i(commit_page), .busy(busy), .done(wr_done), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  spi_nvm_mem #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: rtl/spi_nvm_engine_chk.sv
module spi_nvm_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_act,
  input logic cs_rise,
  input logic hold_act,
  input logic busy,
  input logic mem_we,
  input logic wel,
  input logic so_oe_o,
  input logic out_phase
);
  p_quiet_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !so_oe_o);

  p_hold_floats_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |-> !so_oe_o);

  p_drive_only_output_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe_o |-> out_phase);

  p_array_written_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  p_commit_after_cs_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));

  p_latch_clear_after_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
endmodule

bind spi_nvm_engine spi_nvm_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_rise(cs_rise),
  .hold_act(hold_act), .busy(busy), .mem_we(mem_we), .wel(wel),
  .so_oe_o(so_oe_o), .out_phase(out_phase)
);

// File: tb/spi_nvm_engine_bench.sv
module spi_nvm_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 5;

  logic clk, rst_n, sck, csn, si, holdn;
  logic so, so_oe;
  int   n_run, n_fail, hi_cnt;
  bit   done_flag;

  logic [7:0] mmem [2048];
  logic       mwel, mpen;
  logic [1:0] mbp;

  spi_nvm_engine u_spi_nvm_engine (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .si_i(si),
    .holdn_i(holdn), .so_o(so), .so_oe_o(so_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // every clock: with chip select high the drive enable must be low (R3)
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      if (csn) hi_cnt++; else hi_cnt = 0;
      if (hi_cnt > 4) chk("R3 enable low while deselected", so_oe, 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, all requirements unfinished");
    report();
  end

  function automatic logic [7:0] mstat();
    return {mpen, 3'b000, mbp, mwel, 1'b0};
  endfunction

  task automatic sbyte(input logic [7:0] tx, input logic exp_oe, input int hold_bit,
                       input string tag, output logic [7:0] rx);
    logic oe_ok;
    oe_ok = 1'b1;
    for (int b = 7; b >= 0; b--) begin
      si = tx[b];
      if (b == hold_bit) begin
        tick(HP);
        holdn = 1'b0;
        tick(HP);
        chk("R9 output floats during pause", so_oe, 0);
        repeat (2) begin
          sck = 1'b1; si = ~si; tick(HP);
          sck = 1'b0; tick(HP);
        end
        si = tx[b];
        holdn = 1'b1;
        tick(HP);
      end
      tick(HP);
      rx[b] = so;
      if (so_oe !== exp_oe) oe_ok = 1'b0;
      sck = 1'b1;
      tick(HP);
      sck = 1'b0;
    end
    chk(tag, oe_ok, 1);
  endtask

  task automatic cs_begin;
    csn = 1'b0;
    tick(HP);
  endtask

  task automatic cs_end;
    tick(HP);
    csn = 1'b1;
    tick(3*HP);
  endtask

  task automatic send_op(input logic [7:0] op);
    logic [7:0] rx;
    cs_begin();
    sbyte(op, 0, -1, "R1 instruction phase undriven", rx);
    cs_end();
  endtask

  task automatic rd_status(output logic [7:0] st);
    cs_begin();
    sbyte(8'h05, 0, -1, "R11 status opcode undriven", st);
    sbyte(8'h00, 1, -1, "R11 status byte driven", st);
    cs_end();
  endtask

  task automatic wait_ready(input string tag);
    logic [7:0] st;
    for (int i = 0; i < 20; i++) begin
      rd_status(st);
      if (st[0] == 1'b0) break;
    end
    chk(tag, st, mstat());
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] rx;
    sbyte(a[23:16], 0, -1, "R2 address byte undriven", rx);
    sbyte(a[15:8],  0, -1, "R2 address byte undriven", rx);
    sbyte(a[7:0],   0, -1, "R2 address byte undriven", rx);
  endtask

  task automatic rd_arr(input logic [7:0] op, input logic [23:0] a, input int n,
                        input int hold_at, input string tag);
    logic [7:0]  rx;
    logic [10:0] ix;
    cs_begin();
    sbyte(op, 0, -1, "R1 read opcode undriven", rx);
    send_addr(a);
    for (int i = 0; i < n; i++) begin
      ix = a[10:0] + 11'(i);
      sbyte(8'(i * 29 + 3), 1, (i == 1) ? hold_at : -1, "R5 data phase driven", rx);
      chk(tag, rx, mmem[ix]);
    end
    cs_end();
  endtask

  // probe: 0 = check 0xFF status, 1 = try a read while busy
  task automatic wr_arr(input logic [23:0] a, input int n, input int seed, input int probe);
    logic [7:0] rx, d, st;
    cs_begin();
    sbyte(8'h02, 0, -1, "R1 write opcode undriven", rx);
    send_addr(a);
    for (int i = 0; i < n; i++) begin
      d = 8'(seed + i * 37);
      sbyte(d, 0, -1, "R6 write data undriven", rx);
      if (mwel) mmem[{a[10:8], 8'(a[7:0] + 8'(i))}] = d;
    end
    cs_end();
    if (mwel) begin
      mwel = 1'b0;
      if (probe == 0) begin
        rd_status(st);
        chk("R11 status reads all ones while busy", st, 8'hFF);
      end else begin
        cs_begin();
        sbyte(8'h03, 0, -1, "R11 read ignored while busy", rx);
        send_addr(24'h000000);
        sbyte(8'h00, 0, -1, "R11 read ignored while busy", rx);
        cs_end();
      end
      wait_ready("R10 latch cleared after programming");
    end
  endtask

  initial begin
    logic [7:0] st, rx;
    n_run = 0; n_fail = 0; hi_cnt = 0; done_flag = 1'b0;
    mwel = 1'b0; mpen = 1'b0; mbp = 2'b00;
    rst_n = 1'b0; sck = 1'b0; csn = 1'b1; si = 1'b0; holdn = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk("R12 enable low after reset", so_oe, 0);
    rd_status(st);
    chk("R12 status zero after reset", st, 8'h00);

    // R10: latch set and clear, bit 3 of opcode ignored (R1)
    send_op(8'h06);  mwel = 1'b1;
    rd_status(st);   chk("R10 latch set", st, 8'h02);
    send_op(8'h04);  mwel = 1'b0;
    rd_status(st);   chk("R10 latch cleared", st, 8'h00);
    send_op(8'h0E);  mwel = 1'b1;
    rd_status(st);   chk("R1 bit3 ignored on set", st, 8'h02);

    // fill page 0 fully, read back the start (R6, R5)
    wr_arr(24'h000000, 256, 11, 0);
    rd_arr(8'h03, 24'h000000, 40, -1, "R5 page 0 data");

    // write without latch is ignored (R10)
    wr_arr(24'h000010, 4, 200, 0);
    rd_arr(8'h03, 24'h00000E, 8, -1, "R10 write ignored without latch");

    // page 7 with column wrap and overwrite, upper address bits ignored (R6, R2)
    send_op(8'h06); mwel = 1'b1;
    wr_arr(24'hFE0710, 258, 77, 1);
    rd_arr(8'h03, 24'h00070C, 8, -1, "R6 column wrap overwrite");
    rd_arr(8'h0B, 24'hA807F8, 16, -1, "R5 read wraps top to zero, R2 upper bits ignored");

    // partial page write keeps other columns (R8)
    send_op(8'h06); mwel = 1'b1;
    wr_arr(24'h000081, 3, 150, 0);
    rd_arr(8'h03, 24'h00007C, 12, -1, "R8 only received columns programmed");

    // abort mid-byte: nothing programmed, latch kept (R7)
    send_op(8'h06); mwel = 1'b1;
    cs_begin();
    sbyte(8'h02, 0, -1, "R7 write opcode undriven", rx);
    send_addr(24'h000090);
    sbyte(8'hC3, 0, -1, "R7 data undriven", rx);
    for (int b = 7; b >= 4; b--) begin
      si = b[0]; tick(HP); sck = 1'b1; tick(HP); sck = 1'b0;
    end
    cs_end();
    rd_status(st);
    chk("R7 abort leaves latch and idle", st, 8'h02);
    rd_arr(8'h03, 24'h00008E, 4, -1, "R7 aborted write leaves array");
    send_op(8'h04); mwel = 1'b0;

    // invalid opcodes mute the slave (R4)
    foreach (st[i]) begin end
    cs_begin();
    sbyte(8'h83, 0, -1, "R4 invalid opcode undriven", rx);
    send_addr(24'h000000);
    sbyte(8'h00, 0, -1, "R4 stays muted", rx);
    cs_end();
    cs_begin();
    sbyte(8'h07, 0, -1, "R4 opcode 111 undriven", rx);
    sbyte(8'h05, 0, -1, "R4 later status opcode ignored", rx);
    sbyte(8'h00, 0, -1, "R4 stays muted", rx);
    cs_end();
    rd_arr(8'h03, 24'h000020, 2, -1, "R4 next select works again");

    // pause in mid read (R9)
    rd_arr(8'h03, 24'h000040, 3, 4, "R9 read resumes after pause");

    // status write (R11, R10)
    send_op(8'h06); mwel = 1'b1;
    cs_begin();
    sbyte(8'h01, 0, -1, "R11 status write opcode", rx);
    sbyte(8'hFF, 0, -1, "R11 status write data", rx);
    cs_end();
    mpen = 1'b1; mbp = 2'b11; mwel = 1'b0;
    rd_status(st);
    chk("R11 user bits stored, 6:4 zero, latch cleared", st, 8'h8C);
    cs_begin();
    sbyte(8'h01, 0, -1, "R10 status write without latch", rx);
    sbyte(8'h00, 0, -1, "R10 status write without latch", rx);
    cs_end();
    rd_status(st);
    chk("R10 status write ignored without latch", st, 8'h8C);

    // deselected activity has no effect (R3)
    for (int i = 0; i < 24; i++) begin
      si = i[1]; tick(HP); sck = ~sck;
    end
    sck = 1'b0; tick(HP);
    rd_status(st);
    chk("R3 deselected clocks ignored", st, 8'h8C);

    done_flag = 1'b1;
    report();
  end
endmodule